// File: doc/BRIEF.md
# Flash Buffered-Program Command Sequencer

This block sits on the host side of a static memory bus. It programs a run of one to sixteen words into a pair of 16-bit flash devices that share a 32-bit data path, using the device's buffered-write protocol. A single start pulse carries three values: the erase-block address, the first data address and the word count, encoded as length minus one. The data words then arrive one at a time through a valid/ready handshake.

First the sequencer checks the request. It then writes the buffer setup command to the block address and reads back status. It repeats this setup-and-read pair until both devices report that the buffer is free. Next it writes the count, then the data words at consecutive addresses, then the confirm command. Every command and count value is driven on both 16-bit halves of the bus at the same time, so both devices see the same sequence.

Each bus operation is a request that the block holds steady until the bus side acknowledges it. The block ends the operation with a one-cycle done pulse and a result code. There are four codes: success, rejected request, poll timeout and device error. On a device error, the block writes the clear-status command before it signals done.

Top module: `fbp_seq`

## Requirements
- R1: After reset, busy_o, bus_req_o, done_o and wdat_ready_o are all 0.
- R2: After an accepted start, the first bus operation is a write of 0x00E8_00E8 (0xE8 in bits 7:0 and 23:16) to the block address.
- R3: Each setup write is followed by a status read at the block address. Both devices are ready only when status bit 7 and bit 23 are both 1. When they are not both 1, the setup write and the status read are issued again.
- R4: Once both devices are ready, with no error bit set, the count field (length minus one) is written to the block address. It is placed in bits 3:0 and in bits 19:16, and all other bits are 0.
- R5: Data words are taken in handshake order (a word transfers on a clock edge with wdat_valid_i and wdat_ready_o both high). They are written unchanged to start address + k, for k = 0 up to the count. A pause in wdat_valid_i only delays the writes.
- R6: After the last data word, 0x00D0_00D0 is written to the block address. One cycle after that write is acknowledged, done_o pulses for one cycle with err_code_o = 0.
- R7: A request is rejected when the start address bits 3:0 plus the count exceed 15, or when the start address differs from the block address in any bit at or above BLK_W. A rejected request pulses done_o in the next cycle with err_code_o = 1 and issues no bus request.
- R8: If POLL_MAX status reads in a row find the devices not ready, done_o pulses with err_code_o = 2 and no further bus request is issued.
- R9: A status read that shows both devices ready, but has bit 4, 5, 20 or 21 set, is followed by a write of 0x0050_0050 to the block address and then by done_o with err_code_o = 3. No count write is issued.
- R10: While bus_req_o is high and bus_ack_i is low, bus_req_o stays high and bus_we_o, bus_addr_o and bus_wdata_o do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| blk_addr_i | input | AW | Erase-block word address for commands |
| start_addr_i | input | AW | Word address of the first data word |
| count_i | input | WIN_W | Number of words minus one |
| wdat_valid_i | input | 1 | Data word available |
| wdat_i | input | 16*LANES | Data word |
| wdat_ready_o | output | 1 | Block will take a data word |
| bus_req_o | output | 1 | Bus operation requested |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | AW | Word address of the operation |
| bus_wdata_o | output | 16*LANES | Write data |
| bus_ack_i | input | 1 | Bus operation complete |
| bus_rdata_i | input | 16*LANES | Read data, valid with bus_ack_i |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_code_o | output | 2 | 0 ok, 1 rejected, 2 poll timeout, 3 device error |

## Verification
The full-window run of sixteen words and the single word in the last slot of a window probe both ends of the length range and the address increment. A short aligned run gives the baseline order of commands. Status returns in which neither device is ready, or only the lower one, separate a readiness check that needs both halves from one that looks at one half only. A run that is never ready exercises the timeout limit, and a ready status carrying error bits exercises the clear-status path. Two rejected requests, one crossing the 16-word window and one naming a different erase block, must finish with no bus traffic at all. A pausing data source shows that writes follow the handshake and not a fixed schedule.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_POLL, S_CNT, S_DGET, S_DWR, S_CONF, S_CLR
  } fbp_state_e;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_REJECT  = 2'd1,
    RES_TIMEOUT = 2'd2,
    RES_DEVERR  = 2'd3
  } fbp_res_e;

  localparam logic [7:0] CMD_SETUP   = 8'hE8;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_CLRSTAT = 8'h50;
  localparam int unsigned LANE_W     = 16;
  localparam int unsigned RDY_BIT    = 7;
  localparam int unsigned ERR_BIT_A  = 4;
  localparam int unsigned ERR_BIT_B  = 5;
endpackage

// File: rtl/fbp_range_chk.sv
module fbp_range_chk #(
  parameter int unsigned AW    = 24,
  parameter int unsigned WIN_W = 4,
  parameter int unsigned BLK_W = 16
) (
  input  logic [AW-BLK_W-1:0] blk_hi_i,
  input  logic [AW-BLK_W-1:0] start_hi_i,
  input  logic [WIN_W-1:0]    start_lo_i,
  input  logic [WIN_W-1:0]    count_i,
  output logic                reject_o
);
  logic [WIN_W:0] end_off;

  // carry out of the window offset means the run leaves the aligned window
  assign end_off  = {1'b0, start_lo_i} + {1'b0, count_i};
  assign reject_o = end_off[WIN_W] | (blk_hi_i != start_hi_i);
endmodule

// File: rtl/fbp_poll_cnt.sv
module fbp_poll_cnt #(
  parameter int unsigned POLL_MAX = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned PW = $clog2(POLL_MAX + 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  // high while the read in flight is the POLL_MAX-th
  assign last_o = (cnt_q == PW'(POLL_MAX - 1));
endmodule

// File: rtl/fbp_lane_ops.sv
module fbp_lane_ops #(
  parameter int unsigned LANES = 2
) (
  input  logic [fbp_pkg::LANE_W-1:0]       lane_val_i,
  output logic [fbp_pkg::LANE_W*LANES-1:0] bus_val_o,
  input  logic [fbp_pkg::LANE_W*LANES-1:0] stat_i,
  output logic                             ready_o,
  output logic                             err_o
);
  import fbp_pkg::*;

  logic [LANES-1:0] rdy;
  logic [LANES-1:0] er;
  logic             stat_unused;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign bus_val_o[l*LANE_W +: LANE_W] = lane_val_i;
    assign rdy[l] = stat_i[l*LANE_W + RDY_BIT];
    assign er[l]  = stat_i[l*LANE_W + ERR_BIT_A] | stat_i[l*LANE_W + ERR_BIT_B];
  end

  assign ready_o     = &rdy;
  assign err_o       = |er;
  assign stat_unused = ^stat_i;
endmodule

// File: rtl/fbp_seq.sv
module fbp_seq #(
  parameter int unsigned AW       = 24,
  parameter int unsigned WIN_W    = 4,
  parameter int unsigned BLK_W    = 16,
  parameter int unsigned LANES    = 2,
  parameter int unsigned POLL_MAX = 1024
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             start_i,
  input  logic [AW-1:0]                    blk_addr_i,
  input  logic [AW-1:0]                    start_addr_i,
  input  logic [WIN_W-1:0]                 count_i,
  input  logic                             wdat_valid_i,
  input  logic [fbp_pkg::LANE_W*LANES-1:0] wdat_i,
  output logic                             wdat_ready_o,
  output logic                             bus_req_o,
  output logic                             bus_we_o,
  output logic [AW-1:0]                    bus_addr_o,
  output logic [fbp_pkg::LANE_W*LANES-1:0] bus_wdata_o,
  input  logic                             bus_ack_i,
  input  logic [fbp_pkg::LANE_W*LANES-1:0] bus_rdata_i,
  output logic                             busy_o,
  output logic                             done_o,
  output logic [1:0]                       err_code_o
);
  import fbp_pkg::*;

  localparam int unsigned DW = LANE_W * LANES;

  fbp_state_e          state_q, state_d;
  logic [AW-1:0]       blk_q, addr_q;
  logic [WIN_W-1:0]    cnt_q, rem_q;
  logic [DW-1:0]       data_q;
  logic                done_q;
  fbp_res_e            code_q;

  logic                reject;
  logic                xfer;
  logic                poll_clr, poll_inc, poll_last;
  logic [LANE_W-1:0]   lane_val;
  logic [DW-1:0]       mirrored;
  logic                stat_ready, stat_err;

  fbp_range_chk #(.AW(AW), .WIN_W(WIN_W), .BLK_W(BLK_W)) u_range (
    .blk_hi_i   (blk_addr_i[AW-1:BLK_W]),
    .start_hi_i (start_addr_i[AW-1:BLK_W]),
    .start_lo_i (start_addr_i[WIN_W-1:0]),
    .count_i    (count_i),
    .reject_o   (reject)
  );

  fbp_poll_cnt #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (poll_clr),
    .inc_i  (poll_inc),
    .last_o (poll_last)
  );

  fbp_lane_ops #(.LANES(LANES)) u_lanes (
    .lane_val_i (lane_val),
    .bus_val_o  (mirrored),
    .stat_i     (bus_rdata_i),
    .ready_o    (stat_ready),
    .err_o      (stat_err)
  );

  assign xfer = bus_req_o & bus_ack_i;

  always_comb begin
    unique case (state_q)
      S_SETUP: lane_val = LANE_W'(CMD_SETUP);
      S_CNT:   lane_val = LANE_W'(cnt_q);
      S_CONF:  lane_val = LANE_W'(CMD_CONFIRM);
      S_CLR:   lane_val = LANE_W'(CMD_CLRSTAT);
      default: lane_val = '0;
    endcase
  end

  always_comb begin
    bus_req_o = 1'b0;
    bus_we_o  = 1'b1;
    unique case (state_q)
      S_SETUP, S_CNT, S_DWR, S_CONF, S_CLR: bus_req_o = 1'b1;
      S_POLL: begin bus_req_o = 1'b1; bus_we_o = 1'b0; end
      default: ;
    endcase
  end

  assign bus_addr_o   = (state_q == S_DWR) ? addr_q : blk_q;
  assign bus_wdata_o  = (state_q == S_DWR) ? data_q :
                        (state_q == S_POLL) ? '0 : mirrored;
  assign wdat_ready_o = (state_q == S_DGET);
  assign busy_o       = (state_q != S_IDLE);
  assign done_o       = done_q;
  assign err_code_o   = code_q;

  assign poll_clr = (state_q == S_IDLE);
  assign poll_inc = (state_q == S_POLL) & xfer & ~stat_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (start_i && !reject) state_d = S_SETUP;
      S_SETUP: if (xfer) state_d = S_POLL;
      S_POLL:  if (xfer) begin
                 if (stat_ready)     state_d = stat_err ? S_CLR : S_CNT;
                 else if (poll_last) state_d = S_IDLE;
                 else                state_d = S_SETUP;
               end
      S_CNT:   if (xfer) state_d = S_DGET;
      S_DGET:  if (wdat_valid_i) state_d = S_DWR;
      S_DWR:   if (xfer) state_d = (rem_q == '0) ? S_CONF : S_DGET;
      S_CONF:  if (xfer) state_d = S_IDLE;
      S_CLR:   if (xfer) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      blk_q   <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      rem_q   <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
      code_q  <= RES_OK;
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          if (reject) begin
            done_q <= 1'b1;
            code_q <= RES_REJECT;
          end else begin
            blk_q  <= blk_addr_i;
            addr_q <= start_addr_i;
            cnt_q  <= count_i;
            rem_q  <= count_i;
          end
        end
        S_POLL: if (xfer && !stat_ready && poll_last) begin
          done_q <= 1'b1;
          code_q <= RES_TIMEOUT;
        end
        S_DGET: if (wdat_valid_i) data_q <= wdat_i;
        S_DWR: if (xfer && rem_q != '0) begin
          rem_q  <= rem_q - 1'b1;
          addr_q <= addr_q + 1'b1;
        end
        S_CONF: if (xfer) begin
          done_q <= 1'b1;
          code_q <= RES_OK;
        end
        S_CLR: if (xfer) begin
          done_q <= 1'b1;
          code_q <= RES_DEVERR;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fbp_seq_chk.sv
module fbp_seq_chk #(
  parameter int unsigned AW = 24,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          wdat_ready_o,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [DW-1:0] bus_wdata_o,
  input logic          bus_ack_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [1:0]    err_code_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_we_o) &&
      $stable(bus_addr_o) && $stable(bus_wdata_o)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !bus_req_o && !wdat_ready_o); // R1

  AST_REJECT_IMMEDIATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && err_code_o == 2'd1 |-> $past(start_i) && !$past(busy_o)); // R7

  AST_DATA_NO_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdat_ready_o |-> !bus_req_o); // R5
endmodule

bind fbp_seq fbp_seq_chk #(.AW(AW), .DW(fbp_pkg::LANE_W*LANES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .wdat_ready_o (wdat_ready_o),
  .bus_req_o    (bus_req_o),
  .bus_we_o     (bus_we_o),
  .bus_addr_o   (bus_addr_o),
  .bus_wdata_o  (bus_wdata_o),
  .bus_ack_i    (bus_ack_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_code_o   (err_code_o)
);

// File: tb/sim_fbp_seq.sv
module sim_fbp_seq;
  localparam int AW = 24;
  localparam int DW = 32;

  typedef struct {
    bit          is_done;
    bit          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [1:0]  code;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] blk = '0, saddr = '0;
  logic [3:0] cnt = '0;
  logic wvalid = 1'b0;
  logic [DW-1:0] wdat = '0;
  logic wready, req, we, busy, done;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic ack = 1'b0;
  logic [DW-1:0] rdata = '0;
  logic [1:0] code;

  int errors = 0, checks = 0, cyc = 0, tick = 0;
  bit got_done = 0, gap_en = 0, xfer_flag = 0;
  item_t exp_q[$];
  logic [DW-1:0] stat_q[$];
  logic [DW-1:0] dat_q[$];

  always #10 clk = ~clk;

  fbp_seq #(.AW(AW), .WIN_W(4), .BLK_W(16), .LANES(2), .POLL_MAX(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .blk_addr_i(blk),
    .start_addr_i(saddr), .count_i(cnt), .wdat_valid_i(wvalid), .wdat_i(wdat),
    .wdat_ready_o(wready), .bus_req_o(req), .bus_we_o(we), .bus_addr_o(addr),
    .bus_wdata_o(wdata), .bus_ack_i(ack), .bus_rdata_i(rdata), .busy_o(busy),
    .done_o(done), .err_code_o(code));

  task automatic chk(bit ok, string tag, string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic exp_bus(bit w, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    item_t it;
    it.is_done = 0; it.we = w; it.addr = a; it.data = d; it.code = 0; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic exp_done(logic [1:0] c, string tag);
    item_t it;
    it.is_done = 1; it.we = 0; it.addr = 0; it.data = 0; it.code = c; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // monitor, bus slave and data source
  always @(negedge clk) begin
    tick++;
    if (xfer_flag) void'(dat_q.pop_front());
    wvalid = (dat_q.size() > 0) && !(gap_en && tick[0]);
    wdat   = (dat_q.size() > 0) ? dat_q[0] : '0;
    xfer_flag = wvalid && wready;
    if (ack) ack = 1'b0;
    else if (req) begin
      item_t it;
      ack = 1'b1;
      rdata = (!we && stat_q.size() > 0) ? stat_q.pop_front() : '0;
      if (exp_q.size() == 0 || exp_q[0].is_done)
        chk(0, "R7", $sformatf("unexpected bus op we=%0b addr=%h data=%h expected none", we, addr, wdata));
      else begin
        it = exp_q.pop_front();
        chk(we == it.we && addr == it.addr && (!we || wdata == it.data), it.tag,
            $sformatf("bus we=%0b addr=%h data=%h expected we=%0b addr=%h data=%h",
                      we, addr, wdata, it.we, it.addr, it.data));
      end
    end
    if (done) begin
      item_t it;
      got_done = 1;
      if (exp_q.size() == 0 || !exp_q[0].is_done)
        chk(0, "R6", $sformatf("early done code=%0d expected bus op", code));
      else begin
        it = exp_q.pop_front();
        chk(code == it.code, it.tag, $sformatf("done code=%0d expected %0d", code, it.code));
      end
    end
  end

  task automatic run_op(logic [AW-1:0] b, logic [AW-1:0] s, logic [3:0] c, string tag);
    int guard = 0;
    @(negedge clk);
    blk = b; saddr = s; cnt = c; start = 1'b1; got_done = 0;
    @(negedge clk);
    start = 1'b0;
    while (!got_done && guard < 2000) begin @(negedge clk); guard++; end
    chk(got_done && exp_q.size() == 0, tag,
        $sformatf("pending expectations=%0d done=%0b expected 0 and 1", exp_q.size(), got_done));
    repeat (2) @(negedge clk);
  endtask

  task automatic full_op(logic [AW-1:0] b, logic [AW-1:0] s, logic [3:0] c,
                         int nrdy, logic [DW-1:0] base);
    for (int i = 0; i <= nrdy; i++) begin
      exp_bus(1, b, 32'h00E8_00E8, "R2");
      exp_bus(0, b, '0, "R3");
    end
    exp_bus(1, b, {12'h0, c, 12'h0, c}, "R4");
    for (int k = 0; k <= int'(c); k++) begin
      dat_q.push_back(base + DW'(k));
      exp_bus(1, s + AW'(k), base + DW'(k), "R5");
    end
    exp_bus(1, b, 32'h00D0_00D0, "R6");
    exp_done(2'd0, "R6");
    stat_q.push_back(32'h0080_0080);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !req && !done && !wready, "R1",
        $sformatf("in reset busy=%0b req=%0b done=%0b rdy=%0b expected 0", busy, req, done, wready));
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !req && !done && !wready, "R1",
        $sformatf("after reset busy=%0b req=%0b done=%0b rdy=%0b expected 0", busy, req, done, wready));

    // short aligned run, ready at once
    full_op(24'h12_0000, 24'h12_0040, 4'd3, 0, 32'hA100_0000);
    run_op(24'h12_0000, 24'h12_0040, 4'd3, "R6");

    // not ready twice: neither half, then lower half only
    stat_q.push_back(32'h0000_0000);
    stat_q.push_back(32'h0000_0080);
    full_op(24'h30_0000, 24'h30_1230, 4'd1, 2, 32'hB200_0000);
    run_op(24'h30_0000, 24'h30_1230, 4'd1, "R3");

    // full sixteen-word window
    full_op(24'h05_0000, 24'h05_FFF0, 4'd15, 0, 32'hC300_0000);
    run_op(24'h05_0000, 24'h05_FFF0, 4'd15, "R5");

    // single word in last slot of a window
    full_op(24'h05_0000, 24'h05_000F, 4'd0, 0, 32'hD400_0000);
    run_op(24'h05_0000, 24'h05_000F, 4'd0, "R5");

    // window crossing rejected
    exp_done(2'd1, "R7");
    run_op(24'h05_0000, 24'h05_000D, 4'd3, "R7");

    // erase-block mismatch rejected
    exp_done(2'd1, "R7");
    run_op(24'h06_0000, 24'h05_0000, 4'd0, "R7");

    // poll timeout after four not-ready reads
    for (int i = 0; i < 4; i++) begin
      exp_bus(1, 24'h22_0000, 32'h00E8_00E8, "R8");
      exp_bus(0, 24'h22_0000, '0, "R8");
    end
    exp_done(2'd2, "R8");
    run_op(24'h22_0000, 24'h22_0000, 4'd2, "R8");

    // device error status: ready with bits 5:4 of lower half
    stat_q.push_back(32'h0080_00B0);
    exp_bus(1, 24'h40_0000, 32'h00E8_00E8, "R9");
    exp_bus(0, 24'h40_0000, '0, "R9");
    exp_bus(1, 24'h40_0000, 32'h0050_0050, "R9");
    exp_done(2'd3, "R9");
    run_op(24'h40_0000, 24'h40_0100, 4'd2, "R9");

    // pausing data source
    gap_en = 1;
    full_op(24'h77_0000, 24'h77_0088, 4'd5, 1, 32'hE500_0000);
    stat_q.push_front(32'h0080_0000);
    run_op(24'h77_0000, 24'h77_0088, 4'd5, "R5");
    gap_en = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: cycles=%0d expected completion", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule